// File: doc/BRIEF.md
# Issue Interlock Scoreboard

This block sits between instruction decode and a three-stage back end (execute, memory, write) and decides, every cycle, whether the instruction offered for issue has to wait. The offered instruction brings a latency class code, an optional destination register, up to two address/operand sources and one store-data source, and an addressing-mode description for memory classes. When the instruction issues, the scoreboard records how many more cycles its destination needs before a consumer can pick it up through forwarding. It also records how long the instruction keeps the execute stage occupied. A later instruction is held while the execute stage is occupied or while any source it names is still pending.

Each register has a small down-counter holding "cycles still to wait". The counter is loaded at issue with the class latency minus one and counts down every clock. A source is usable when its counter reads zero. Word loads also mark their destination so that a store right behind them may take the loaded value as its store data one cycle early. A flush input discards all pending state at once.

Top module: `issue_interlock_sb`

## Requirements
- R1: Class 1 (plain ALU, also shift by constant) has latency 1: a consumer of its destination presented in the very next cycle issues without stall.
- R2: Class 2 (ALU with shift amount from a register) keeps execute busy for two cycles: any valid instruction offered in the next cycle stalls exactly one cycle, and its destination is ready two cycles after issue.
- R3: Classes 3 (byte load) and 4 (word load) have latency 2: a consumer offered in the next cycle stalls exactly one cycle.
- R4: A class-5 store offered in the cycle right after a class-4 word load, naming the loaded register only as its store data, issues without stall. The early pickup does not apply when the register is also an address source, when the producer is a byte load, or when the consumer is not a store.
- R5: For classes 3, 4 and 5 with the scaled flag set, execute is held for three cycles and load latency grows by two. The exceptions take one cycle and add no latency: subtract flag 0 with shift amount 0 or 2, and subtract flag 1 with shift amount 0. With the scaled flag clear, one cycle.
- R6: Multiply classes give (latency, execute cycles): 6 (2,1), 7 (2,2), 8 (3,2), 9 (3,4), 10 (4,3), 11 (4,5).
- R7: Classes 0 (branch), 5 (store) and 12 to 15, and any instruction with the destination flag clear, leave no pending result.
- R8: Register index 0 is tracked exactly like every other register.
- R9: A flush clears all pending counters and the execute occupancy in the same edge, and an instruction offered during the flush cycle is not recorded.
- R10: Stall is high only when the valid input is high and either execute is occupied or a used source (either address/operand source, or store data) is pending. After reset nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Discard all pending state |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_class | input | 4 | Latency class code |
| iss_has_dst | input | 1 | Instruction writes a register |
| iss_dst | input | RW | Destination register index |
| iss_a_used | input | 1 | First source is read |
| iss_a | input | RW | First source index |
| iss_b_used | input | 1 | Second source is read |
| iss_b | input | RW | Second source index |
| iss_d_used | input | 1 | Store-data source is read |
| iss_d | input | RW | Store-data source index |
| iss_scaled | input | 1 | Memory access uses a scaled register offset |
| iss_sub | input | 1 | Offset is subtracted from the base |
| iss_shamt | input | SH_W | Left shift applied to the offset |
| stall | output | 1 | Hold the offered instruction this cycle |

## Verification
A wrong per-register counter shows at the stall output the first time a consumer naming that register is offered: a counter that is too high holds that consumer for extra cycles, and one that is too low lets it through a cycle early. A wrong execute-occupancy count shows in the very next cycle as a stall present or missing for any valid instruction, whatever registers it names. A stale early-pickup mark only shows when a store with matching data follows a load directly, so the vectors place loads and stores back to back with every combination of producer kind and source port.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [3:0] {
      SB_NONE      = 4'd0,
      SB_ALU       = 4'd1,
      SB_ALU_SHREG = 4'd2,
      SB_LD_BYTE   = 4'd3,
      SB_LD_WORD   = 4'd4,
      SB_STORE     = 4'd5,
      SB_MUL16     = 4'd6,
      SB_MAC16     = 4'd7,
      SB_MUL       = 4'd8,
      SB_MULS      = 4'd9,
      SB_MULL      = 4'd10,
      SB_MULLS     = 4'd11
   } sb_class_e;

   typedef struct packed {
      logic       has_res;
      logic [2:0] lat;
      logic [2:0] occ;
      logic       word_ld;
      logic       is_mem;
   } sb_timing_t;

   function automatic sb_timing_t sb_base_timing(input logic [3:0] code);
      sb_timing_t t;
      case (sb_class_e'(code))
         SB_ALU:       t = '{1'b1, 3'd1, 3'd1, 1'b0, 1'b0};
         SB_ALU_SHREG: t = '{1'b1, 3'd2, 3'd2, 1'b0, 1'b0};
         SB_LD_BYTE:   t = '{1'b1, 3'd2, 3'd1, 1'b0, 1'b1};
         SB_LD_WORD:   t = '{1'b1, 3'd2, 3'd1, 1'b1, 1'b1};
         SB_STORE:     t = '{1'b0, 3'd0, 3'd1, 1'b0, 1'b1};
         SB_MUL16:     t = '{1'b1, 3'd2, 3'd1, 1'b0, 1'b0};
         SB_MAC16:     t = '{1'b1, 3'd2, 3'd2, 1'b0, 1'b0};
         SB_MUL:       t = '{1'b1, 3'd3, 3'd2, 1'b0, 1'b0};
         SB_MULS:      t = '{1'b1, 3'd3, 3'd4, 1'b0, 1'b0};
         SB_MULL:      t = '{1'b1, 3'd4, 3'd3, 1'b0, 1'b0};
         SB_MULLS:     t = '{1'b1, 3'd4, 3'd5, 1'b0, 1'b0};
         default:      t = '{1'b0, 3'd0, 3'd1, 1'b0, 1'b0};
      endcase
      return t;
   endfunction

endpackage

// File: rtl/sb_class_decode.sv
module sb_class_decode
   import sb_pkg::*;
#(
   parameter int CNT_W = 3,
   parameter int OCC_W = 3,
   parameter int SH_W  = 5
) (
   input  logic [3:0]       code,
   input  logic             scaled,
   input  logic             sub,
   input  logic [SH_W-1:0]  shamt,
   output logic             has_res,
   output logic [CNT_W-1:0] cnt_init,
   output logic [OCC_W-1:0] occ_m1,
   output logic             word_ld
);

   sb_timing_t t;
   logic       fast_mode;
   logic       slow;
   logic [3:0] lat_sum;
   logic [3:0] occ_sum;

   always_comb begin
      t         = sb_base_timing(code);
      fast_mode = (!sub && (shamt == '0 || shamt == SH_W'(2))) ||
                  (sub && shamt == '0);
      slow      = t.is_mem && scaled && !fast_mode;
      lat_sum   = {1'b0, t.lat} + (slow ? 4'd2 : 4'd0);
      occ_sum   = slow ? 4'd3 : {1'b0, t.occ};
      has_res   = t.has_res;
      word_ld   = t.word_ld;
      cnt_init  = (lat_sum == 4'd0) ? '0 : CNT_W'(lat_sum - 4'd1);
      occ_m1    = OCC_W'(occ_sum - 4'd1);
   end

endmodule

// File: rtl/sb_reg_slot.sv
module sb_reg_slot #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic             wr_byp,
   output logic [CNT_W-1:0] cnt,
   output logic             byp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         byp <= 1'b0;
      end else if (flush) begin
         cnt <= '0;
         byp <= 1'b0;
      end else if (wr) begin
         cnt <= wr_cnt;
         byp <= wr_byp;
      end else begin
         if (cnt != '0) cnt <= cnt - 1'b1;
         if (cnt <= CNT_W'(1)) byp <= 1'b0;
      end
   end

endmodule

// File: rtl/sb_occ_timer.sv
module sb_occ_timer #(
   parameter int OCC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             load,
   input  logic [OCC_W-1:0] load_val,
   output logic [OCC_W-1:0] busy_cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy_cnt <= '0;
      else if (flush)            busy_cnt <= '0;
      else if (load)             busy_cnt <= load_val;
      else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
   end

endmodule

// File: rtl/issue_interlock_sb.sv
module issue_interlock_sb
   import sb_pkg::*;
#(
   parameter int NREG         = 16,
   parameter int CNT_W        = 3,
   parameter int OCC_W        = 3,
   parameter int SH_W         = 5,
   parameter bit STORE_BYPASS = 1'b1,
   localparam int RW          = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            iss_valid,
   input  logic [3:0]      iss_class,
   input  logic            iss_has_dst,
   input  logic [RW-1:0]   iss_dst,
   input  logic            iss_a_used,
   input  logic [RW-1:0]   iss_a,
   input  logic            iss_b_used,
   input  logic [RW-1:0]   iss_b,
   input  logic            iss_d_used,
   input  logic [RW-1:0]   iss_d,
   input  logic            iss_scaled,
   input  logic            iss_sub,
   input  logic [SH_W-1:0] iss_shamt,
   output logic            stall
);

   if (NREG < 2 || NREG != (1 << RW)) begin : g_chk_nreg
      $error("NREG must be a power of two, at least 2");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("CNT_W must hold a count of 3");
   end
   if (OCC_W < 3) begin : g_chk_occ
      $error("OCC_W must hold an occupancy of 4");
   end
   if (SH_W < 2) begin : g_chk_sh
      $error("SH_W must hold a shift of 2");
   end

   logic             dec_res;
   logic [CNT_W-1:0] dec_cnt;
   logic [OCC_W-1:0] dec_occ;
   logic             dec_word;
   logic [OCC_W-1:0] busy_cnt;
   logic [CNT_W-1:0] slot_cnt [NREG];
   logic             slot_byp [NREG];
   logic [NREG-1:0]  slot_wr;
   logic             issue;
   logic             a_wait, b_wait, d_wait;
   logic             is_store;

   sb_class_decode #(.CNT_W(CNT_W), .OCC_W(OCC_W), .SH_W(SH_W)) u_dec (
      .code     (iss_class),
      .scaled   (iss_scaled),
      .sub      (iss_sub),
      .shamt    (iss_shamt),
      .has_res  (dec_res),
      .cnt_init (dec_cnt),
      .occ_m1   (dec_occ),
      .word_ld  (dec_word)
   );

   sb_occ_timer #(.OCC_W(OCC_W)) u_occ (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .load     (issue),
      .load_val (dec_occ),
      .busy_cnt (busy_cnt)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      sb_reg_slot #(.CNT_W(CNT_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .flush  (flush),
         .wr     (slot_wr[g]),
         .wr_cnt (dec_cnt),
         .wr_byp (dec_word),
         .cnt    (slot_cnt[g]),
         .byp    (slot_byp[g])
      );
   end

   assign is_store = (iss_class == SB_STORE);
   assign a_wait   = iss_a_used && (slot_cnt[iss_a] != '0);
   assign b_wait   = iss_b_used && (slot_cnt[iss_b] != '0);

   if (STORE_BYPASS) begin : g_byp
      assign d_wait = iss_d_used && (slot_cnt[iss_d] != '0) &&
                      !(is_store && slot_cnt[iss_d] == CNT_W'(1) && slot_byp[iss_d]);
   end else begin : g_nobyp
      assign d_wait = iss_d_used && (slot_cnt[iss_d] != '0);
   end

   assign stall = iss_valid && ((busy_cnt != '0) || a_wait || b_wait || d_wait);
   assign issue = iss_valid && !stall && !flush;

   always_comb begin
      for (int i = 0; i < NREG; i++) begin
         slot_wr[i] = issue && iss_has_dst && dec_res && (iss_dst == RW'(i));
      end
   end

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
   parameter int NREG  = 16,
   parameter int RW    = 4,
   parameter int CNT_W = 3,
   parameter int OCC_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             iss_valid,
   input logic [3:0]       iss_class,
   input logic             iss_has_dst,
   input logic [RW-1:0]    iss_dst,
   input logic             stall,
   input logic [OCC_W-1:0] busy,
   input logic [CNT_W-1:0] slot_cnt [NREG]
);

   logic issue;
   assign issue = iss_valid && !stall && !flush;

   assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !stall);

   assert_stall_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> iss_valid);

   assert_busy_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy != '0 && iss_valid) |-> stall);

   assert_shreg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && iss_class == 4'd2) |=> (busy == OCC_W'(1)));

   assert_mulls_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && iss_class == 4'd11) |=> (busy == OCC_W'(4)));

   assert_busy_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy <= OCC_W'(4));

   assert_nodst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !iss_has_dst && !flush) |=>
         (slot_cnt[$past(iss_dst)] ==
          (($past(slot_cnt[iss_dst]) == '0) ? '0 : CNT_W'($past(slot_cnt[iss_dst]) - 1'b1))));

endmodule

bind issue_interlock_sb sb_checker #(
   .NREG(NREG), .RW(RW), .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .iss_valid   (iss_valid),
   .iss_class   (iss_class),
   .iss_has_dst (iss_has_dst),
   .iss_dst     (iss_dst),
   .stall       (stall),
   .busy        (busy_cnt),
   .slot_cnt    (slot_cnt)
);

// File: tb/issue_interlock_sb_test.sv
`timescale 1ns/1ps
module issue_interlock_sb_test;

   localparam int RW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic iss_valid = 1'b0;
   logic [3:0] iss_class = '0;
   logic iss_has_dst = 1'b0;
   logic [RW-1:0] iss_dst = '0;
   logic iss_a_used = 1'b0;
   logic [RW-1:0] iss_a = '0;
   logic iss_b_used = 1'b0;
   logic [RW-1:0] iss_b = '0;
   logic iss_d_used = 1'b0;
   logic [RW-1:0] iss_d = '0;
   logic iss_scaled = 1'b0;
   logic iss_sub = 1'b0;
   logic [4:0] iss_shamt = '0;
   logic stall;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   issue_interlock_sb uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
      .iss_class(iss_class), .iss_has_dst(iss_has_dst), .iss_dst(iss_dst),
      .iss_a_used(iss_a_used), .iss_a(iss_a), .iss_b_used(iss_b_used), .iss_b(iss_b),
      .iss_d_used(iss_d_used), .iss_d(iss_d), .iss_scaled(iss_scaled),
      .iss_sub(iss_sub), .iss_shamt(iss_shamt), .stall(stall)
   );

   typedef struct packed {
      logic       v;
      logic [3:0] c;
      logic       hd;
      logic [3:0] dst;
      logic       ua;
      logic [3:0] a;
      logic       ub;
      logic [3:0] b;
      logic       ud;
      logic [3:0] d;
      logic       scl;
      logic       sub;
      logic [4:0] sh;
      logic       fl;
      logic       ex;
      logic [3:0] rq;
   } vec_t;

   // fields: v cls hd dst ua a ub b ud d scl sub sh fl expected_stall req
   localparam int NV = 59;
   localparam vec_t VEC [NV] = '{
      '{1, 1,1, 1, 0, 0,0,0,0,0, 0,0,0, 0,0, 1},  // R1 ALU r1
      '{1, 1,1, 2, 1, 1,0,0,0,0, 0,0,0, 0,0, 1},  // R1 back to back
      '{1, 2,1, 3, 1, 2,0,0,0,0, 0,0,0, 0,0, 2},  // R2 shift by reg
      '{1, 1,1, 4, 1, 3,0,0,0,0, 0,0,0, 0,1, 2},  // R2 held
      '{1, 1,1, 4, 1, 3,0,0,0,0, 0,0,0, 0,0, 2},
      '{1, 3,1, 5, 1, 4,0,0,0,0, 0,0,0, 0,0, 3},  // R3 byte load
      '{1, 1,1, 6, 1, 5,0,0,0,0, 0,0,0, 0,1, 3},
      '{1, 1,1, 6, 1, 5,0,0,0,0, 0,0,0, 0,0, 3},
      '{1, 4,1, 7, 1, 0,0,0,0,0, 0,0,0, 0,0, 3},  // R3 word load
      '{1, 5,0, 0, 1, 1,0,0,1,7, 0,0,0, 0,0, 4},  // R4 store data pickup
      '{1, 4,1, 8, 0, 0,0,0,0,0, 0,0,0, 0,0, 4},
      '{1, 5,0, 0, 1, 8,0,0,1,1, 0,0,0, 0,1, 4},  // R4 address use stalls
      '{1, 5,0, 0, 1, 8,0,0,1,1, 0,0,0, 0,0, 4},
      '{1, 3,1, 9, 0, 0,0,0,0,0, 0,0,0, 0,0, 4},
      '{1, 5,0, 0, 0, 0,0,0,1,9, 0,0,0, 0,1, 4},  // R4 byte load no pickup
      '{1, 5,0, 0, 0, 0,0,0,1,9, 0,0,0, 0,0, 4},
      '{1, 4,1,10, 0, 0,0,0,0,0, 1,0,2, 0,0, 5},  // R5 add lsl2 fast
      '{1, 1,1,11, 0, 0,0,0,0,0, 0,0,0, 0,0, 5},
      '{1, 4,1,10, 0, 0,0,0,0,0, 1,1,0, 0,0, 5},  // R5 sub lsl0 fast
      '{1, 1,1,11, 0, 0,0,0,0,0, 0,0,0, 0,0, 5},
      '{1, 3,1,12, 0, 0,0,0,0,0, 1,0,1, 0,0, 5},  // R5 add lsl1 slow
      '{1, 1,1,13, 0, 0,0,0,0,0, 0,0,0, 0,1, 5},
      '{1, 1,1,13, 0, 0,0,0,0,0, 0,0,0, 0,1, 5},
      '{1, 1,1,13, 1,12,0,0,0,0, 0,0,0, 0,1, 5},  // R5 latency +2
      '{1, 1,1,13, 1,12,0,0,0,0, 0,0,0, 0,0, 5},
      '{1, 5,0, 0, 0, 0,0,0,0,0, 1,1,2, 0,0, 5},  // R5 sub lsl2 slow store
      '{1, 1,1,14, 0, 0,0,0,0,0, 0,0,0, 0,1, 5},
      '{1, 1,1,14, 0, 0,0,0,0,0, 0,0,0, 0,1, 5},
      '{1, 1,1,14, 0, 0,0,0,0,0, 0,0,0, 0,0, 5},
      '{1,10,1,15, 0, 0,0,0,0,0, 0,0,0, 0,0, 6},  // R6 long multiply
      '{1, 1,1, 1, 1,15,0,0,0,0, 0,0,0, 0,1, 6},
      '{1, 1,1, 1, 1,15,0,0,0,0, 0,0,0, 0,1, 6},
      '{1, 1,1, 1, 1,15,0,0,0,0, 0,0,0, 0,1, 6},
      '{1, 1,1, 1, 1,15,0,0,0,0, 0,0,0, 0,0, 6},
      '{1, 3,1, 0, 0, 0,0,0,0,0, 0,0,0, 0,0, 8},  // R8 write r0
      '{1, 1,1, 2, 1, 0,0,0,0,0, 0,0,0, 0,1, 8},
      '{1, 1,1, 2, 1, 0,0,0,0,0, 0,0,0, 0,0, 8},
      '{1, 3,0, 3, 0, 0,0,0,0,0, 0,0,0, 0,0, 7},  // R7 no dst flag
      '{1, 1,1, 4, 1, 3,0,0,0,0, 0,0,0, 0,0, 7},
      '{1, 0,1, 4, 0, 0,0,0,0,0, 0,0,0, 0,0, 7},  // R7 branch
      '{1, 1,1, 5, 1, 4,0,0,0,0, 0,0,0, 0,0, 7},
      '{1, 8,1, 5, 0, 0,0,0,0,0, 0,0,0, 0,0, 6},  // R6 multiply
      '{0, 0,0, 0, 0, 0,0,0,0,0, 0,0,0, 0,0,10},  // R10 idle no stall
      '{1, 1,1, 6, 1, 5,0,0,0,0, 0,0,0, 0,1, 6},
      '{1, 1,1, 6, 1, 5,0,0,0,0, 0,0,0, 0,0, 6},
      '{1,11,1, 7, 0, 0,0,0,0,0, 0,0,0, 0,0, 6},  // R6 flag long multiply
      '{1, 1,1, 8, 0, 0,0,0,0,0, 0,0,0, 0,1, 6},
      '{1, 1,1, 8, 0, 0,0,0,0,0, 0,0,0, 0,1, 6},
      '{1, 1,1, 8, 0, 0,0,0,0,0, 0,0,0, 0,1, 6},
      '{1, 1,1, 8, 0, 0,0,0,0,0, 0,0,0, 0,1, 6},
      '{1, 1,1, 8, 0, 0,0,0,0,0, 0,0,0, 0,0, 6},
      '{1, 3,1, 9, 0, 0,0,0,0,0, 0,0,0, 0,0,10},
      '{1, 1,1,10, 0, 0,1,9,0,0, 0,0,0, 0,1,10},  // R10 second source
      '{1, 1,1,10, 0, 0,1,9,0,0, 0,0,0, 0,0,10},
      '{1,10,1,10, 0, 0,0,0,0,0, 0,0,0, 0,0, 9},
      '{1, 1,1,11, 1,10,0,0,0,0, 0,0,0, 1,1, 9},  // R9 flush
      '{1, 1,1,11, 1,10,0,0,0,0, 0,0,0, 0,0, 9},
      '{1, 3,1,11, 0, 0,0,0,0,0, 0,0,0, 1,0, 9},  // R9 not recorded
      '{1, 1,1,12, 1,11,0,0,0,0, 0,0,0, 0,0, 9}
   };

   task automatic apply(input vec_t t);
      iss_valid   = t.v;
      iss_class   = t.c;
      iss_has_dst = t.hd;
      iss_dst     = t.dst;
      iss_a_used  = t.ua;
      iss_a       = t.a;
      iss_b_used  = t.ub;
      iss_b       = t.b;
      iss_d_used  = t.ud;
      iss_d       = t.d;
      iss_scaled  = t.scl;
      iss_sub     = t.sub;
      iss_shamt   = t.sh;
      flush       = t.fl;
   endtask

   task automatic check(input logic got, input logic exp, input string req, input int idx);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s step %0d stall=%0b expected=%0b", req, idx, got, exp);
      end
   endtask

   function automatic vec_t mk(input logic [3:0] c, input logic hd, input logic [3:0] dst,
                               input logic ua, input logic [3:0] a,
                               input logic ud, input logic [3:0] d);
      vec_t t;
      t = '0;
      t.v = 1'b1; t.c = c; t.hd = hd; t.dst = dst;
      t.ua = ua; t.a = a; t.ud = ud; t.d = d;
      return t;
   endfunction

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         apply('0);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state: every source clear after reset
      @(negedge clk);
      apply(mk(4'd1, 1'b1, 4'd1, 1'b1, 4'd0, 1'b1, 4'd15));
      iss_b_used = 1'b1; iss_b = 4'd7;
      #1 check(stall, 1'b0, "R10", -1);
      idle(1);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(VEC[i]);
         #1 check(stall, VEC[i].ex, $sformatf("R%0d", VEC[i].rq), i);
      end
      idle(6);

      // R10 reset during pending work clears it
      @(negedge clk);
      apply(mk(4'd10, 1'b1, 4'd2, 1'b0, 4'd0, 1'b0, 4'd0));
      @(negedge clk);
      apply('0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      apply(mk(4'd1, 1'b1, 4'd3, 1'b1, 4'd2, 1'b0, 4'd0));
      #1 check(stall, 1'b0, "R10", 100);
      idle(6);

      // R4 loaded register as both address and data: stall
      @(negedge clk);
      apply(mk(4'd4, 1'b1, 4'd3, 1'b0, 4'd0, 1'b0, 4'd0));
      @(negedge clk);
      apply(mk(4'd5, 1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 4'd3));
      #1 check(stall, 1'b1, "R4", 101);
      idle(6);

      // R4 non-store consumer on data port gets no early pickup
      @(negedge clk);
      apply(mk(4'd4, 1'b1, 4'd4, 1'b0, 4'd0, 1'b0, 4'd0));
      @(negedge clk);
      apply(mk(4'd1, 1'b1, 4'd5, 1'b0, 4'd0, 1'b1, 4'd4));
      #1 check(stall, 1'b1, "R4", 102);
      idle(6);

      // R6 class 9: latency 3, four execute cycles
      @(negedge clk);
      apply(mk(4'd9, 1'b1, 4'd6, 1'b0, 4'd0, 1'b0, 4'd0));
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         apply(mk(4'd1, 1'b1, 4'd7, 1'b1, 4'd6, 1'b0, 4'd0));
         #1 check(stall, 1'b1, "R6", 103 + k);
      end
      @(negedge clk);
      #1 check(stall, 1'b0, "R6", 106);
      idle(4);

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

endmodule